// File: doc/BRIEF.md
# Compare Flags and Conditional Branch Unit

This block keeps the condition state of a small 32-bit processor and settles its conditional branches. A compare strobe captures two register values and stores five ordering flags in a condition register: equality, signed less/greater and unsigned less/greater. The flags stay in the register until the next compare.

A branch strobe presents a 16-bit instruction word and the address of that instruction. The unit recognises a conditional branch by its two top bits and reads a 4-bit condition selector from the word. It tests that condition against the stored flags. It then produces the next program counter, a one-cycle taken pulse, or a one-cycle illegal-instruction pulse when the selector is not defined. The core around the block does the instruction fetch, holds the register file, handles memory and acts on the illegal flag.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset, `next_pc_o` is 0, `taken_o` and `illegal_o` are 0, and all five condition flags are 0. With the flags at 0, the not-equal condition holds and every other condition fails.
- R2: On a cycle with `cmp_en_i` high, all five flags are rewritten at the clock edge. EQ is set when A equals B. LT and GT come from a two's-complement comparison of A and B. LTU and GTU come from an unsigned comparison.
- R3: While `cmp_en_i` is low, the flags keep their value whatever `cmp_a_i` and `cmp_b_i` carry.
- R4: A word is a conditional branch only when bits 15 and 14 are both 1. Any other word presented with `br_en_i` gives no taken pulse and no illegal pulse, and `next_pc_o` becomes `pc_i + 2`.
- R5: The offset is bits 9:0 of the word, read as a signed value and multiplied by 2. A taken branch sets `next_pc_o` to `pc_i + 2 + offset`, with the sum wrapping modulo 2^32. The full offset range is -1024 to +1022.
- R6: Selector bits 13:10 take the branch on these conditions: 0 on EQ, 1 on not EQ, 2 on LT, 3 on GT, 4 on LTU, 5 on GTU.
- R7: Selector 6 takes the branch on GT or EQ, 7 on LT or EQ, 8 on GTU or EQ, and 9 on LTU or EQ.
- R8: Selectors 10 to 15 pulse `illegal_o` and never `taken_o`. In that case `next_pc_o` becomes `pc_i + 2`.
- R9: The outputs are registered. `next_pc_o`, `taken_o` and `illegal_o` show the result in the cycle after the branch strobe. `taken_o` and `illegal_o` are high for that one cycle only, and `next_pc_o` holds until the next branch strobe.
- R10: A branch uses the flags written by compares at earlier clock edges. A branch strobed in the cycle right after a compare already sees that compare's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_en_i | input | 1 | Compare strobe |
| cmp_a_i | input | 32 | First compare operand |
| cmp_b_i | input | 32 | Second compare operand |
| br_en_i | input | 1 | Branch strobe; never high in the same cycle as `cmp_en_i` |
| br_word_i | input | 16 | Instruction word to resolve |
| pc_i | input | 32 | Address of the instruction in `br_word_i` |
| next_pc_o | output | 32 | Resolved next program counter |
| taken_o | output | 1 | One-cycle pulse: the branch was taken |
| illegal_o | output | 1 | One-cycle pulse: undefined condition selector |

## Verification
The hardest cases are operand pairs where the signed and unsigned orderings disagree, such as all-ones against one, or the most negative value against the most positive. Those pairs are the only ones that separate the LT/GT paths from the LTU/GTU paths, so the stimulus applies each of them and then sweeps all sixteen selectors. The sweep also covers the extreme offsets and a PC that wraps across zero. The stimulus places some branches directly after a compare, with no idle cycle between them. It also inserts idle cycles where the operand inputs change while the compare strobe is low, to show the flags hold.

// File: rtl/cmp_branch_pkg.sv
package cmp_branch_pkg;

  // Width of the condition selector field; ten conditions need four bits.
  localparam int SEL_W = 4;

  typedef struct packed {
    logic eq;
    logic lt;
    logic gt;
    logic ltu;
    logic gtu;
  } cc_t;

  typedef enum logic [SEL_W-1:0] {
    C_EQ  = 4'd0,
    C_NE  = 4'd1,
    C_LT  = 4'd2,
    C_GT  = 4'd3,
    C_LTU = 4'd4,
    C_GTU = 4'd5,
    C_GE  = 4'd6,
    C_LE  = 4'd7,
    C_GEU = 4'd8,
    C_LEU = 4'd9
  } cond_e;

  localparam logic [SEL_W-1:0] LAST_LEGAL = 4'd9;

  function automatic logic sel_legal(input logic [SEL_W-1:0] sel);
    return sel <= LAST_LEGAL;
  endfunction

  function automatic logic cond_holds(input logic [SEL_W-1:0] sel, input cc_t cc);
    logic r;
    case (cond_e'(sel))
      C_EQ:    r = cc.eq;
      C_NE:    r = !cc.eq;
      C_LT:    r = cc.lt;
      C_GT:    r = cc.gt;
      C_LTU:   r = cc.ltu;
      C_GTU:   r = cc.gtu;
      C_GE:    r = cc.gt  | cc.eq;
      C_LE:    r = cc.lt  | cc.eq;
      C_GEU:   r = cc.gtu | cc.eq;
      C_LEU:   r = cc.ltu | cc.eq;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg
  import cmp_branch_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_en,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output cc_t          flags_q
);

  cc_t flags_d;

  always_comb begin
    flags_d.eq  = (op_a == op_b);
    flags_d.lt  = ($signed(op_a) < $signed(op_b));
    flags_d.gt  = ($signed(op_a) > $signed(op_b));
    flags_d.ltu = (op_a < op_b);
    flags_d.gtu = (op_a > op_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (cmp_en) flags_q <= flags_d;
  end

endmodule

// File: rtl/br_decode.sv
module br_decode
  import cmp_branch_pkg::*;
#(
  parameter int W    = 32,
  parameter int IW   = 16,
  parameter int OFFW = 10
) (
  input  logic [IW-1:0] word,
  input  cc_t           flags,
  output logic          is_branch,
  output logic          legal,
  output logic          cond_met,
  output logic [W-1:0]  offset
);

  localparam int SEL_LO = IW - 2 - SEL_W;

  logic [SEL_W-1:0] sel;

  assign sel       = word[IW-3 -: SEL_W];
  assign is_branch = (word[IW-1:IW-2] == 2'b11);
  assign legal     = sel_legal(sel);
  assign cond_met  = cond_holds(sel, flags);
  assign offset    = {{(W-OFFW-1){word[OFFW-1]}}, word[OFFW-1:0], 1'b0};

  initial begin
    if (SEL_LO != OFFW) $error("selector field must sit directly above the offset");
  end

endmodule

// File: rtl/pc_resolve.sv
module pc_resolve #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         br_en,
  input  logic [W-1:0] pc,
  input  logic         is_branch,
  input  logic         legal,
  input  logic         cond_met,
  input  logic [W-1:0] offset,
  output logic [W-1:0] next_pc_q,
  output logic         taken_q,
  output logic         illegal_q
);

  logic [W-1:0] seq_pc;
  logic         take;
  logic         bad;

  assign seq_pc = pc + W'(2);
  assign take   = is_branch && legal && cond_met;
  assign bad    = is_branch && !legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc_q <= '0;
      taken_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      taken_q   <= br_en && take;
      illegal_q <= br_en && bad;
      if (br_en) next_pc_q <= take ? seq_pc + offset : seq_pc;
    end
  end

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cmp_branch_pkg::*;
#(
  parameter int W    = 32,
  parameter int IW   = 16,
  parameter int OFFW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en_i,
  input  logic [W-1:0]  cmp_a_i,
  input  logic [W-1:0]  cmp_b_i,
  input  logic          br_en_i,
  input  logic [IW-1:0] br_word_i,
  input  logic [W-1:0]  pc_i,
  output logic [W-1:0]  next_pc_o,
  output logic          taken_o,
  output logic          illegal_o
);

  cc_t          flags;
  logic         br_is_branch;
  logic         br_legal;
  logic         br_cond;
  logic [W-1:0] br_off;

  cmp_flag_reg #(.W(W)) i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_en  (cmp_en_i),
    .op_a    (cmp_a_i),
    .op_b    (cmp_b_i),
    .flags_q (flags)
  );

  br_decode #(.W(W), .IW(IW), .OFFW(OFFW)) i_dec (
    .word      (br_word_i),
    .flags     (flags),
    .is_branch (br_is_branch),
    .legal     (br_legal),
    .cond_met  (br_cond),
    .offset    (br_off)
  );

  pc_resolve #(.W(W)) i_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_en     (br_en_i),
    .pc        (pc_i),
    .is_branch (br_is_branch),
    .legal     (br_legal),
    .cond_met  (br_cond),
    .offset    (br_off),
    .next_pc_q (next_pc_o),
    .taken_q   (taken_o),
    .illegal_q (illegal_o)
  );

endmodule

// File: rtl/cmp_branch_unit_chk.sv
module cmp_branch_unit_chk
  import cmp_branch_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_en_i,
  input logic [W-1:0]  cmp_a_i,
  input logic [W-1:0]  cmp_b_i,
  input logic          br_en_i,
  input logic [IW-1:0] br_word_i,
  input logic [W-1:0]  pc_i,
  input logic [W-1:0]  next_pc_o,
  input logic          taken_o,
  input logic          illegal_o,
  input cc_t           flags,
  input logic          br_is_branch,
  input logic          br_legal,
  input logic          br_cond,
  input logic [W-1:0]  br_off
);

  // R2
  eq_excludes_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.eq |-> !(flags.lt || flags.gt || flags.ltu || flags.gtu));

  // R2
  equal_ops_set_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_i && cmp_a_i == cmp_b_i) |=> flags.eq);

  // R2
  signed_order_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flags.lt, flags.gt}) <= 1);

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en_i |=> $stable(flags));

  // R5
  taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_en_i && br_is_branch && br_legal && br_cond)
      |=> taken_o && next_pc_o == $past(pc_i) + W'(2) + $past(br_off));

  // R4
  not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_en_i && !taken_o) |=> (taken_o || next_pc_o == $past(pc_i) + W'(2)));

  // R8
  illegal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_en_i && br_word_i[IW-1:IW-2] == 2'b11 && br_word_i[IW-3 -: SEL_W] > 4'd9)
      |=> illegal_o && !taken_o);

  // R9
  pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_en_i |=> !taken_o && !illegal_o);

  // R8
  taken_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_o && illegal_o));

endmodule

bind cmp_branch_unit cmp_branch_unit_chk #(.W(W), .IW(IW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_en_i     (cmp_en_i),
  .cmp_a_i      (cmp_a_i),
  .cmp_b_i      (cmp_b_i),
  .br_en_i      (br_en_i),
  .br_word_i    (br_word_i),
  .pc_i         (pc_i),
  .next_pc_o    (next_pc_o),
  .taken_o      (taken_o),
  .illegal_o    (illegal_o),
  .flags        (flags),
  .br_is_branch (br_is_branch),
  .br_legal     (br_legal),
  .br_cond      (br_cond),
  .br_off       (br_off)
);

// File: tb/test_cmp_branch_unit.sv
module test_cmp_branch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_en_i = 1'b0;
  logic [31:0] cmp_a_i = '0;
  logic [31:0] cmp_b_i = '0;
  logic        br_en_i = 1'b0;
  logic [15:0] br_word_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] next_pc_o;
  logic        taken_o;
  logic        illegal_o;

  always #2.5 clk = ~clk;

  cmp_branch_unit i_cmp_branch_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_en_i  (cmp_en_i),
    .cmp_a_i   (cmp_a_i),
    .cmp_b_i   (cmp_b_i),
    .br_en_i   (br_en_i),
    .br_word_i (br_word_i),
    .pc_i      (pc_i),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o),
    .illegal_o (illegal_o)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R1";

  // Reference state: the last compared operands, not flags.
  bit          m_have = 0;
  logic [31:0] m_a = '0, m_b = '0;
  logic [31:0] m_pc = '0;
  bit          m_taken = 0, m_ill = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_have = 0; m_a = '0; m_b = '0; m_pc = '0; m_taken = 0; m_ill = 0;
    end else begin
      m_taken = 0;
      m_ill   = 0;
      if (br_en_i) begin
        bit eq, sl, sg, ul, ug, hit;
        int sel, off;
        eq = m_have && (m_a == m_b);
        sl = m_have && (int'(m_a) < int'(m_b));
        sg = m_have && (int'(m_a) > int'(m_b));
        ul = m_have && (longint'({32'd0, m_a}) < longint'({32'd0, m_b}));
        ug = m_have && (longint'({32'd0, m_a}) > longint'({32'd0, m_b}));
        sel = int'(br_word_i[13:10]);
        off = int'(br_word_i[9:0]);
        if (off >= 512) off = off - 1024;
        hit = 0;
        if (br_word_i[15] && br_word_i[14]) begin
          if (sel >= 10) m_ill = 1;
          else if (sel == 0) hit = eq;
          else if (sel == 1) hit = !eq;
          else if (sel == 2) hit = sl;
          else if (sel == 3) hit = sg;
          else if (sel == 4) hit = ul;
          else if (sel == 5) hit = ug;
          else if (sel == 6) hit = sg || eq;
          else if (sel == 7) hit = sl || eq;
          else if (sel == 8) hit = ug || eq;
          else               hit = ul || eq;
        end
        m_taken = hit;
        m_pc = pc_i + 32'd2 + (hit ? 32'(off * 2) : 32'd0);
      end
      if (cmp_en_i) begin
        m_have = 1; m_a = cmp_a_i; m_b = cmp_b_i;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (next_pc_o !== m_pc) begin
        fails++;
        $display("FAIL %s next_pc actual=%h expected=%h", tag, next_pc_o, m_pc);
      end
      checks++;
      if (taken_o !== m_taken) begin
        fails++;
        $display("FAIL %s taken actual=%b expected=%b", tag, taken_o, m_taken);
      end
      checks++;
      if (illegal_o !== m_ill) begin
        fails++;
        $display("FAIL %s illegal actual=%b expected=%b", tag, illegal_o, m_ill);
      end
    end
  end

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input string t);
    tag = t; cmp_en_i = 1; cmp_a_i = a; cmp_b_i = b;
    @(negedge clk);
    cmp_en_i = 0;
  endtask

  task automatic do_br(input logic [15:0] w, input logic [31:0] pc, input string t);
    tag = t; br_en_i = 1; br_word_i = w; pc_i = pc;
    @(negedge clk);
    br_en_i = 0;
  endtask

  task automatic idle(input int n, input string t);
    tag = t;
    for (int i = 0; i < n; i++) begin
      cmp_a_i = 32'hA5A5_0000 + 32'(i); cmp_b_i = ~cmp_a_i;
      br_word_i = 16'hC000 | 16'(i);
      @(negedge clk);
    end
  endtask

  task automatic sweep(input logic [31:0] pc, input logic [9:0] off, input string t);
    for (int s = 0; s < 16; s++) begin
      do_br({2'b11, 4'(s), off}, pc + 32'(s * 4), t);
    end
  endtask

  initial begin
    // R1 reset values observed during and just after reset
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 with zero flags: NE taken, EQ not
    do_br(16'hC405, 32'h100, "R1");
    do_br(16'hC005, 32'h100, "R1");
    // R2 R6 R7 R10 equal operands, branch right after compare
    do_cmp(32'd5, 32'd5, "R2");
    sweep(32'h0000_1000, 10'h010, "R6_R7_eq");
    // R2 signed and unsigned orderings disagree
    do_cmp(32'hFFFF_FFFF, 32'd1, "R2");
    sweep(32'h0000_2000, 10'h1FF, "R6_R7_neg_vs_pos");
    do_cmp(32'd1, 32'hFFFF_FFFF, "R10");
    sweep(32'h0000_3000, 10'h200, "R5_R6_R7");
    do_cmp(32'h8000_0000, 32'h7FFF_FFFF, "R2");
    sweep(32'h0000_4000, 10'h3FF, "R6_R7_minmax");
    do_cmp(32'd3, 32'd7, "R2");
    // R3 operands wiggle without strobe; flags must hold
    idle(6, "R3");
    sweep(32'h0000_5000, 10'h155, "R3_R8");
    // R5 wrap across zero with most negative offset
    do_cmp(32'd9, 32'd9, "R5");
    do_br(16'hC200, 32'h0000_0010, "R5");
    do_br(16'hC1FF, 32'hFFFF_FFF0, "R5");
    // R4 words that are not branches
    do_br(16'h4012, 32'h700, "R4");
    do_br(16'h8012, 32'h704, "R4");
    do_br(16'h0000, 32'h708, "R4");
    // R8 undefined selectors back to back
    do_br(16'hE800, 32'h800, "R8");
    do_br(16'hFC01, 32'h804, "R8");
    // R9 next_pc holds, pulses drop
    idle(4, "R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule